// File: doc/BRIEF.md
# Bipolar Zero-Suppression Line Decoder

This block takes a bipolar line as two rail samples, a positive-pulse rail and a negative-pulse rail, one sample per accepted input beat. It rebuilds the unipolar data stream. In B3ZS mode or HDB3 mode it recognises the substitution patterns that the far end inserted in place of long zero runs and turns them back into zeros. With the bypass control set, it performs plain AMI decoding only. Alongside the data it watches the raw line for bipolar violations, excessive-zero runs and loss of signal.

Data moves on valid/ready handshakes at both edges. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready`). An output beat is held, unchanged, for as long as `out_ready` stays low, and no new input is taken while it waits. Every accepted input beat advances a four-slot window, so the decoded bit for a sample leaves the block on the accept of the fourth sample after it.

Status comes out on plain pins. Three live bits report loss of signal and whether the last accumulation period held any violation or excessive-zero event. A six-bit sticky vector records events. Bits in the sticky vector are cleared by a one-cycle write strobe carrying a mask of ones.

Top module: `bzs_decoder`

## Requirements
- R1: `in_ready` equals `out_ready OR NOT out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R2: The decoded bit of the sample accepted on beat k becomes `out_data` with `out_valid` high right after the accept of beat k+4. Beats 0 to 3 after reset produce no output. A sample with a pulse on either rail decodes as 1 and a sample with no pulse decodes as 0.
- R3: A violation is a pulse with the same polarity as the previous pulse. The first pulse after reset is never a violation.
- R4: In B3ZS mode, a violation whose preceding sample held no pulse is a signature. That violation and the two samples before it decode as 0, and sticky bit 0 (code detect) sets.
- R5: In HDB3 mode, a violation whose two preceding samples held no pulse is a signature. That violation and the three samples before it decode as 0, and sticky bit 0 sets.
- R6: A violation that is not a signature sets sticky bit 1.
- R7: An excessive-zero event fires on the sample where a run of raw zero samples reaches 3 in B3ZS mode or 4 in HDB3 mode. It sets sticky bit 2.
- R8: Loss of signal (`st_los`) rises on the 32nd consecutive zero sample. Once high, it falls after 32 consecutive samples that are each a pulse or are still short of the excessive-zero length. Every change of `st_los` sets sticky bit 5.
- R9: `st_viol_nz` and `st_exz_nz` are updated at the end of each period of ACC_LEN accepted samples. Each is 1 when its event occurred in that period. Sticky bits 3 and 4 set only when the matching live bit goes from 0 to 1.
- R10: When `zs_bypass` is 1, no signature is removed, every pulse decodes as 1, every violation sets sticky bit 1, and `st_los` is forced to 0 from the next cycle on.
- R11: A write with `wr_en` high clears each sticky bit whose `wr_clr` bit is 1 and leaves all other sticky bits unchanged. An event that sets a bit in the same cycle as its clear takes precedence, and the bit stays 1.
- R12: A sample with both rails high is taken as a positive pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_pos | input | 1 | Positive-rail pulse |
| in_neg | input | 1 | Negative-rail pulse |
| out_valid | output | 1 | Decoded bit present |
| out_ready | input | 1 | Sink takes the decoded bit |
| out_data | output | 1 | Decoded unipolar bit |
| hdb3_mode | input | 1 | 1 selects HDB3, 0 selects B3ZS |
| zs_bypass | input | 1 | 1 gives AMI-only decoding and holds loss of signal low |
| st_los | output | 1 | Live loss of signal |
| st_viol_nz | output | 1 | Last period held a violation |
| st_exz_nz | output | 1 | Last period held an excessive-zero event |
| lat_status | output | 6 | Sticky bits: 0 code, 1 violation, 2 excessive zero, 3 violation-period rise, 4 excessive-zero-period rise, 5 loss-of-signal change |
| wr_en | input | 1 | Sticky clear strobe |
| wr_clr | input | 6 | Mask of sticky bits to clear |

## Verification
A clear strobe and a new event aimed at the same sticky bit can arrive in the same cycle. This happens when a write to the violation bit is issued together with the accept of a sample that repeats the previous polarity. The test does this by raising `wr_en` in the same cycle as that input beat. The bit is then read back as set, then a plain clear is issued and the bit is read back as cleared. Separately, a write that masks a different bit is shown to leave the violation bit untouched.

// File: rtl/bzs_pkg.sv
package bzs_pkg;
  localparam int SIG_SPAN = 4;
  localparam int LAT_W    = 6;

  localparam int LB_CODE = 0;
  localparam int LB_VIOL = 1;
  localparam int LB_EXZ  = 2;
  localparam int LB_VNZ  = 3;
  localparam int LB_ZNZ  = 4;
  localparam int LB_LOS  = 5;

  typedef struct packed {
    logic vld;
    logic mark;
    logic pol;
    logic dat;
  } slot_t;
endpackage

// File: rtl/bzs_pipe.sv
module bzs_pipe
  import bzs_pkg::*;
#(
  parameter int SPAN = SIG_SPAN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mark,
  input  logic pol,
  input  logic hdb3,
  input  logic bypass,
  output logic tail_vld,
  output logic tail_dat,
  output logic code_ev,
  output logic viol_ev
);
  localparam int B3_BACK = 2;
  localparam int H3_BACK = 3;

  slot_t win [SPAN];
  logic  ref_ok, ref_pol;
  logic  bv, sig;
  int    back_n;

  // violation test against the last pulse polarity
  always_comb begin
    bv      = mark && ref_ok && (pol == ref_pol);
    if (hdb3) sig = bv && !bypass && !win[0].mark && !win[1].mark;
    else      sig = bv && !bypass && !win[0].mark;
    back_n  = hdb3 ? H3_BACK : B3_BACK;
    code_ev = adv && sig;
    viol_ev = adv && bv && !sig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_ok  <= 1'b0;
      ref_pol <= 1'b0;
    end else if (adv && mark) begin
      ref_ok  <= 1'b1;
      ref_pol <= pol;
    end
  end

  // shift window; a signature retroactively zeroes the slots it covers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPAN; i++) win[i] <= '0;
    end else if (adv) begin
      win[0] <= '{vld: 1'b1, mark: mark, pol: pol, dat: mark && !sig};
      for (int i = 1; i < SPAN; i++) begin
        win[i] <= win[i-1];
        if (sig && (i - 1) < back_n) win[i].dat <= 1'b0;
      end
    end
  end

  assign tail_vld = win[SPAN-1].vld;
  assign tail_dat = win[SPAN-1].dat;
endmodule

// File: rtl/bzs_monitor.sv
module bzs_monitor #(
  parameter int LOS_ZEROS = 32,
  parameter int LOS_CLEAN = 32,
  parameter int EXZ_B3    = 3,
  parameter int EXZ_H3    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mark,
  input  logic hdb3,
  input  logic bypass,
  output logic exz_ev,
  output logic los,
  output logic los_chg
);
  localparam int RW = $clog2(LOS_ZEROS + 1);
  localparam int CW = $clog2(LOS_CLEAN + 1);

  logic [RW-1:0] run, run_nx, thr;
  logic [CW-1:0] cln;
  logic          clean, los_nx;

  always_comb begin
    run_nx = run;
    if (mark) run_nx = '0;
    else if (run != RW'(LOS_ZEROS)) run_nx = run + 1'b1;
    thr    = hdb3 ? RW'(EXZ_H3) : RW'(EXZ_B3);
    clean  = mark || (run_nx < thr);
    exz_ev = adv && !mark && (run_nx == thr) && (run != thr);
    los_nx = los;
    if (bypass) los_nx = 1'b0;
    else if (adv) begin
      if (!los) los_nx = (run_nx == RW'(LOS_ZEROS));
      else if (clean && (cln == CW'(LOS_CLEAN - 1))) los_nx = 1'b0;
    end
    los_chg = (los_nx != los);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
      cln <= '0;
      los <= 1'b0;
    end else begin
      los <= los_nx;
      if (adv) run <= run_nx;
      if (!los) cln <= '0;
      else if (adv) cln <= clean ? cln + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/bzs_status.sv
module bzs_status
  import bzs_pkg::*;
#(
  parameter int ACC_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             code_ev,
  input  logic             viol_ev,
  input  logic             exz_ev,
  input  logic             los_chg,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_clr,
  output logic             viol_nz,
  output logic             exz_nz,
  output logic [LAT_W-1:0] lat
);
  localparam int AW   = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
  localparam int NACC = 2;

  logic [AW-1:0]    tick;
  logic             wrap;
  logic [NACC-1:0]  ev, nz, rise;
  logic [LAT_W-1:0] set_v;

  assign wrap = adv && (tick == AW'(ACC_LEN - 1));
  assign ev   = {exz_ev, viol_ev};

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else if (adv) tick <= wrap ? '0 : tick + 1'b1;
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic seen, q, q_nx;
    assign q_nx    = wrap ? (seen || ev[g]) : q;
    assign rise[g] = q_nx && !q;
    assign nz[g]   = q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen <= 1'b0;
        q    <= 1'b0;
      end else begin
        q <= q_nx;
        if (wrap) seen <= 1'b0;
        else if (ev[g]) seen <= 1'b1;
      end
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[LB_CODE] = code_ev;
    set_v[LB_VIOL] = viol_ev;
    set_v[LB_EXZ]  = exz_ev;
    set_v[LB_VNZ]  = rise[0];
    set_v[LB_ZNZ]  = rise[1];
    set_v[LB_LOS]  = los_chg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else lat <= (lat & ~(wr_en ? wr_clr : '0)) | set_v;
  end

  assign viol_nz = nz[0];
  assign exz_nz  = nz[1];
endmodule

// File: rtl/bzs_decoder.sv
module bzs_decoder
  import bzs_pkg::*;
#(
  parameter int ACC_LEN   = 64,
  parameter int LOS_ZEROS = 32,
  parameter int LOS_CLEAN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_pos,
  input  logic             in_neg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_data,
  input  logic             hdb3_mode,
  input  logic             zs_bypass,
  output logic             st_los,
  output logic             st_viol_nz,
  output logic             st_exz_nz,
  output logic [LAT_W-1:0] lat_status,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_clr
);
  logic adv, mark, pol;
  logic tail_vld, tail_dat;
  logic code_ev, viol_ev, exz_ev, los_chg;

  assign in_ready = out_ready || !out_valid;
  assign adv      = in_valid && in_ready;
  assign mark     = in_pos || in_neg;
  assign pol      = in_pos;

  bzs_pipe #(.SPAN(SIG_SPAN)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mark(mark), .pol(pol),
    .hdb3(hdb3_mode), .bypass(zs_bypass),
    .tail_vld(tail_vld), .tail_dat(tail_dat),
    .code_ev(code_ev), .viol_ev(viol_ev)
  );

  bzs_monitor #(.LOS_ZEROS(LOS_ZEROS), .LOS_CLEAN(LOS_CLEAN)) u_mon (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mark(mark),
    .hdb3(hdb3_mode), .bypass(zs_bypass),
    .exz_ev(exz_ev), .los(st_los), .los_chg(los_chg)
  );

  bzs_status #(.ACC_LEN(ACC_LEN)) u_stat (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .code_ev(code_ev), .viol_ev(viol_ev), .exz_ev(exz_ev), .los_chg(los_chg),
    .wr_en(wr_en), .wr_clr(wr_clr),
    .viol_nz(st_viol_nz), .exz_nz(st_exz_nz), .lat(lat_status)
  );

  // output register of the stream edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
    end else if (adv) begin
      out_valid <= tail_vld;
      out_data  <= tail_dat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bzs_decoder_chk.sv
module bzs_decoder_chk
  import bzs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_data,
  input logic             zs_bypass,
  input logic             st_los,
  input logic             st_viol_nz,
  input logic [LAT_W-1:0] lat_status,
  input logic             wr_en
);
  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  in_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  bypass_los_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zs_bypass |=> !st_los);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((lat_status & $past(lat_status)) == $past(lat_status)));

  // R8
  los_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_los != $past(st_los)) |-> lat_status[LB_LOS]);

  // R9
  vnz_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_viol_nz) |-> lat_status[LB_VNZ]);
endmodule

bind bzs_decoder bzs_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .zs_bypass(zs_bypass),
  .st_los(st_los), .st_viol_nz(st_viol_nz), .lat_status(lat_status),
  .wr_en(wr_en)
);

// File: tb/sim_bzs_decoder.sv
`timescale 1ns/1ps
module sim_bzs_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic       in_ready, out_valid, out_data;
  logic       out_ready = 1'b1;
  logic       hdb3_mode = 1'b0, zs_bypass = 1'b0;
  logic       st_los, st_viol_nz, st_exz_nz;
  logic [5:0] lat_status;
  logic       wr_en = 1'b0;
  logic [5:0] wr_clr = '0;

  int checks = 0;
  int errors = 0;
  int lastpol = -1;
  bit got[$];

  always #10 clk = ~clk;

  bzs_decoder #(.ACC_LEN(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pos(in_pos), .in_neg(in_neg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .hdb3_mode(hdb3_mode), .zs_bypass(zs_bypass),
    .st_los(st_los), .st_viol_nz(st_viol_nz), .st_exz_nz(st_exz_nz),
    .lat_status(lat_status), .wr_en(wr_en), .wr_clr(wr_clr)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_data);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit hdb3, bit byp);
    rst_n = 1'b0; hdb3_mode = hdb3; zs_bypass = byp; out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1; got.delete(); lastpol = -1; rst_n = 1'b1;
  endtask

  // sym: 1 positive, -1 negative, 0 none, 2 both rails
  task automatic push(int sym);
    in_pos = (sym == 1 || sym == 2);
    in_neg = (sym == -1 || sym == 2);
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (sym == 1 || sym == 2) lastpol = 1;
    else if (sym == -1) lastpol = -1;
  endtask

  task automatic mark_alt(); push(-lastpol); endtask
  task automatic viol();     push(lastpol);  endtask

  task automatic wr(logic [5:0] m);
    @(posedge clk); #1; wr_en = 1'b1; wr_clr = m;
    @(posedge clk); #1; wr_en = 1'b0; wr_clr = '0;
  endtask

  task automatic run_stream(string req, int s[$], bit e[$]);
    int bad = 0, first = -1;
    foreach (s[i]) push(s[i]);
    repeat (4) push(0);
    repeat (3) @(posedge clk);
    #1;
    check(got.size() == e.size(), {req, " length"}, got.size(), e.size());
    foreach (e[i]) if (i < got.size() && got[i] != e[i]) begin
      bad++; if (first < 0) first = i;
    end
    check(bad == 0, {req, " data at index"}, first, -1);
  endtask

  task automatic t_reset();
    do_reset(0, 0);
    check(out_valid == 0 && lat_status == 0 && st_los == 0 && in_ready == 1,
          "R1 reset state", {out_valid, lat_status}, 0);
  endtask

  task automatic t_latency();
    do_reset(0, 0);
    push(0); push(1); push(-1); push(1);
    check(out_valid == 0, "R2 no output before beat 4", out_valid, 0);
    push(-1);
    check(out_valid == 1 && out_data == 0, "R2 sample0 after beat 4", {out_valid, out_data}, 2);
    push(0);
    check(out_valid == 1 && out_data == 1, "R2 mark decodes as 1", {out_valid, out_data}, 3);
  endtask

  task automatic t_backpressure();
    do_reset(0, 0);
    out_ready = 1'b0;
    push(0); push(1); push(-1); push(1); push(-1);
    @(negedge clk);
    check(in_ready == 0, "R1 in_ready low while held", in_ready, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1 && out_data == 0, "R1 output held", {out_valid, out_data}, 2);
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1, "R1 in_ready back", in_ready, 1);
  endtask

  task automatic t_b3zs();
    int s[$] = '{1, 0, 0, 1, -1, 1, 0, 1, -1};
    bit e[$] = '{1, 0, 0, 0, 1, 0, 0, 0, 1};
    do_reset(0, 0);
    run_stream("R4 B3ZS removal", s, e);
    check(lat_status[0] == 1, "R4 code detect", lat_status[0], 1);
    check(lat_status[1] == 0, "R6 no stray violation", lat_status[1], 0);
  endtask

  task automatic t_hdb3();
    int s[$] = '{1, 0, 0, 0, 1, -1, 1, 0, 0, 1, -1};
    bit e[$] = '{1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1};
    do_reset(1, 0);
    run_stream("R5 HDB3 removal", s, e);
    check(lat_status[0] == 1 && lat_status[1] == 0, "R5 code detect only",
          lat_status[1:0], 1);
  endtask

  task automatic t_bypass();
    int s[$] = '{1, 0, 0, 1, -1, 1, 0, 1, -1};
    bit e[$] = '{1, 0, 0, 1, 1, 1, 0, 1, 1};
    do_reset(0, 1);
    run_stream("R10 AMI only", s, e);
    check(lat_status[0] == 0 && lat_status[1] == 1, "R10 violations not removed",
          lat_status[1:0], 2);
  endtask

  task automatic t_violation();
    do_reset(0, 0);
    push(1);
    check(lat_status[1] == 0, "R3 first pulse not a violation", lat_status[1], 0);
    push(1);
    check(lat_status[1] == 1 && lat_status[0] == 0, "R6 violation without signature",
          lat_status[1:0], 2);
  endtask

  task automatic t_both_rails();
    do_reset(0, 0);
    push(-1); push(2);
    check(lat_status[1] == 0, "R12 both rails alternate from negative", lat_status[1], 0);
    push(1);
    check(lat_status[1] == 1, "R12 both rails set positive reference", lat_status[1], 1);
  endtask

  task automatic t_exz();
    do_reset(0, 0);
    push(1); push(0); push(0);
    check(lat_status[2] == 0, "R7 B3ZS two zeros", lat_status[2], 0);
    push(0);
    check(lat_status[2] == 1, "R7 B3ZS third zero", lat_status[2], 1);
    do_reset(1, 0);
    push(1); push(0); push(0); push(0);
    check(lat_status[2] == 0, "R7 HDB3 three zeros", lat_status[2], 0);
    push(0);
    check(lat_status[2] == 1, "R7 HDB3 fourth zero", lat_status[2], 1);
  endtask

  task automatic t_los();
    do_reset(0, 0);
    repeat (31) push(0);
    check(st_los == 0, "R8 31 zeros", st_los, 0);
    push(0);
    check(st_los == 1 && lat_status[5] == 1, "R8 los rises", {st_los, lat_status[5]}, 3);
    wr(6'b100000);
    check(lat_status[5] == 0, "R11 clear los-change bit", lat_status[5], 0);
    repeat (31) mark_alt();
    check(st_los == 1 && lat_status[5] == 0, "R8 31 clean samples", {st_los, lat_status[5]}, 2);
    mark_alt();
    check(st_los == 0 && lat_status[5] == 1, "R8 los falls", {st_los, lat_status[5]}, 1);
  endtask

  task automatic t_los_bypass();
    do_reset(0, 0);
    repeat (32) push(0);
    check(st_los == 1, "R8 los up before bypass", st_los, 1);
    zs_bypass = 1'b1;
    @(posedge clk); #1;
    check(st_los == 0, "R10 bypass forces los low", st_los, 0);
    repeat (40) push(0);
    check(st_los == 0, "R10 los cannot rise", st_los, 0);
    zs_bypass = 1'b0;
  endtask

  task automatic t_period();
    do_reset(0, 0);
    mark_alt(); viol();
    repeat (13) mark_alt();
    check(st_viol_nz == 0, "R9 before period end", st_viol_nz, 0);
    mark_alt();
    check(st_viol_nz == 1 && lat_status[3] == 1, "R9 period with violation",
          {st_viol_nz, lat_status[3]}, 3);
    wr(6'b001000);
    viol();
    repeat (15) mark_alt();
    check(st_viol_nz == 1 && lat_status[3] == 0, "R9 no rise no latch",
          {st_viol_nz, lat_status[3]}, 2);
    repeat (16) mark_alt();
    check(st_viol_nz == 0 && st_exz_nz == 0, "R9 quiet period", {st_viol_nz, st_exz_nz}, 0);
  endtask

  task automatic t_clear_race();
    do_reset(0, 0);
    mark_alt(); viol();
    check(lat_status[1] == 1, "R6 violation latched", lat_status[1], 1);
    wr(6'b000001);
    check(lat_status[1] == 1, "R11 other mask bit leaves it", lat_status[1], 1);
    wr_en = 1'b1; wr_clr = 6'b000010;
    viol();
    wr_en = 1'b0; wr_clr = '0;
    check(lat_status[1] == 1, "R11 set wins over clear", lat_status[1], 1);
    wr(6'b000010);
    check(lat_status[1] == 0, "R11 plain clear", lat_status[1], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_backpressure();
    t_b3zs();
    t_hdb3();
    t_bypass();
    t_violation();
    t_both_rails();
    t_exz();
    t_los();
    t_los_bypass();
    t_period();
    t_clear_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule